// File: doc/BRIEF.md
# Flattened Butterfly Route Selector

This block picks the output port for a packet at one router of a 64-terminal, two-dimension flattened butterfly. The network has sixteen routers laid out as a 4x4 grid, and four terminals hang off each router. A router has ten ports: four terminal ports, three ports to the other routers in its row, and three ports to the other routers in its column. Every router is wired to every other router in its row, and to every other router in its column. A single hop therefore settles a whole coordinate.

The router presents a destination identifier with its own row and column. The block answers one cycle later with an output port, a virtual channel and a flag that marks the hop as a detour. The column is always resolved before the row. When adaptive mode is on, the block makes a separate choice in each dimension. It compares the queue depth of the direct peer port with the depth of an alternative peer port that the caller picks at random. It then either goes straight to the target coordinate or detours through an intermediate router in that same dimension. A packet that has already taken its detour in the current dimension is sent the direct way, on the upper virtual channel.

Top module: `fbfly_route`

## Requirements
- R1: While reset is asserted, `respValid` is 0 and `outPort`, `outVc` and `outDetour` are 0.
- R2: A request accepted on a rising edge produces `respValid`=1 on the next edge. A cycle with no request gives `respValid`=0 on the next edge.
- R3: When the destination row (bits [5:4]) and column (bits [3:2]) both equal the router's own, `outPort` is the terminal index in bits [1:0] (ports 0 to 3), with `outVc`=0 and `outDetour`=0.
- R4: When the destination column differs from the router's own, the hop uses a row port (4 to 6), even if the row also differs.
- R5: When the column matches and the row differs, the hop uses a column port (7 to 9).
- R6: A peer coordinate t seen from own coordinate o maps to slot t when t<o and to slot t-1 when t>o. The port is the dimension base (4 for row ports, 7 for column ports) plus that slot.
- R7: In adaptive mode, the direct port is kept when its occupancy is no more than twice the occupancy of the alternative port, and the equal-to-twice case keeps it.
- R8: Otherwise the packet detours to the alternative coordinate, and `outDetour`=1. That coordinate is found by listing the coordinates other than own and target in ascending order; `altPick`=0 takes the first and `altPick`=1 the second.
- R9: With `arrivedDetour`=1, a non-ejecting packet takes the direct port with `outVc`=1 and `outDetour`=0, whatever the occupancies. Otherwise `outVc`=0.
- R10: With `adaptiveEn`=0, the direct port is always chosen and `outDetour`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Route request strobe |
| destId | input | 6 | Destination: row [5:4], column [3:2], terminal [1:0] |
| myRow | input | 2 | This router's row |
| myCol | input | 2 | This router's column |
| adaptiveEn | input | 1 | Enable per-dimension adaptive choice |
| arrivedDetour | input | 1 | Packet already detoured in its current dimension |
| altPick | input | 1 | Random selector of the alternative coordinate |
| occDim1 | input | 15 | Row-port queue occupancies, slot p at [p*5 +: 5] |
| occDim2 | input | 15 | Column-port queue occupancies, slot p at [p*5 +: 5] |
| respValid | output | 1 | Result valid |
| outPort | output | 4 | Selected output port 0..9 |
| outVc | output | 1 | Virtual channel for the hop |
| outDetour | output | 1 | Hop is a non-minimal detour |

## Verification
The bench builds the block with its default parameters: a 4x4 grid, four terminals per router and 5-bit occupancies. Because the grid is 4 wide, there are exactly two alternative coordinates per dimension, so both values of `altPick` reach a real candidate. With 5-bit occupancies, the bench can set a direct depth exactly twice the alternative depth and also one above it, which covers the boundary of R7. It also places routers at the edge and in the middle of each coordinate range, so the peer-slot skip of R6 is exercised both below and above the router's own coordinate.

// File: rtl/fbfly_route_pkg.sv
package fbfly_route_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;     // capture a new result
    logic eject;    // deliver to a local terminal
    logic useDim2;  // hop in the column dimension
    logic detour;   // take the alternative peer
    logic vcHigh;   // second virtual channel
  } route_ctrl_t;

endpackage

// File: rtl/fbfly_route_ctrl.sv
module fbfly_route_ctrl
  import fbfly_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        adaptiveEn,
  input  logic        arrivedDetour,
  input  logic        colMatch,
  input  logic        rowMatch,
  input  logic [1:0]  minWins,
  output route_ctrl_t ctrl,
  output logic        respValid
);

  logic ejectNow;
  logic dimSel;

  assign ejectNow = colMatch && rowMatch;
  // the column is settled first; once it matches, the row is worked on
  assign dimSel   = colMatch;

  always_comb begin
    ctrl.load    = reqValid;
    ctrl.eject   = ejectNow;
    ctrl.useDim2 = dimSel;
    ctrl.detour  = adaptiveEn && !arrivedDetour && !ejectNow && !minWins[dimSel];
    ctrl.vcHigh  = arrivedDetour && !ejectNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) respValid <= 1'b0;
    else        respValid <= reqValid;
  end

endmodule

// File: rtl/fbfly_route_dp.sv
module fbfly_route_dp
  import fbfly_route_pkg::*;
#(
  parameter  int K       = 4,
  parameter  int CONC    = 4,
  parameter  int OCC_W   = 5,
  localparam int COORD_W = $clog2(K),
  localparam int TERM_W  = $clog2(CONC),
  localparam int ID_W    = 2 * COORD_W + TERM_W,
  localparam int PEERS   = K - 1,
  localparam int PEER_W  = $clog2(PEERS),
  localparam int PORT_W  = $clog2(CONC + 2 * PEERS),
  localparam int ALT_W   = (K > 3) ? $clog2(K - 2) : 1
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ID_W-1:0]          destId,
  input  logic [COORD_W-1:0]       myRow,
  input  logic [COORD_W-1:0]       myCol,
  input  logic [ALT_W-1:0]         altPick,
  input  logic [PEERS*OCC_W-1:0]   occDim1,
  input  logic [PEERS*OCC_W-1:0]   occDim2,
  input  route_ctrl_t              ctrl,
  output logic                     colMatch,
  output logic                     rowMatch,
  output logic [1:0]               minWins,
  output logic [PORT_W-1:0]        outPort,
  output logic                     outVc,
  output logic                     outDetour
);

  localparam logic [PORT_W-1:0] DIM1_BASE = PORT_W'(CONC);
  localparam logic [PORT_W-1:0] DIM2_BASE = PORT_W'(CONC + PEERS);

  logic [COORD_W-1:0] destRow, destCol;
  logic [TERM_W-1:0]  destTerm;

  assign destRow  = destId[ID_W-1 -: COORD_W];
  assign destCol  = destId[TERM_W +: COORD_W];
  assign destTerm = destId[TERM_W-1:0];
  assign colMatch = (destCol == myCol);
  assign rowMatch = (destRow == myRow);

  logic [1:0][COORD_W-1:0]     ownC, tgtC;
  logic [1:0][PEERS*OCC_W-1:0] occAll;
  logic [1:0][PEER_W-1:0]      minIdx, altIdx;

  assign ownC[0]   = myCol;
  assign tgtC[0]   = destCol;
  assign occAll[0] = occDim1;
  assign ownC[1]   = myRow;
  assign tgtC[1]   = destRow;
  assign occAll[1] = occDim2;

  // peers are numbered with the router's own coordinate left out
  function automatic logic [PEER_W-1:0] peerSlot(input logic [COORD_W-1:0] t,
                                                  input logic [COORD_W-1:0] o);
    logic [COORD_W-1:0] s;
    s = (t > o) ? t - 1'b1 : t;
    return PEER_W'(s);
  endfunction

  for (genvar d = 0; d < 2; d++) begin : g_dim
    logic [COORD_W-1:0] altLoc;
    logic [PEER_W-1:0]  minSlot, altSlot;
    logic [OCC_W-1:0]   minOcc, altOcc;

    // the altPick-th coordinate that is neither own nor target
    always_comb begin
      logic [ALT_W:0] cnt;
      cnt    = '0;
      altLoc = '0;
      for (int c = 0; c < K; c++) begin
        if (COORD_W'(c) != ownC[d] && COORD_W'(c) != tgtC[d]) begin
          if (cnt == {1'b0, altPick}) altLoc = COORD_W'(c);
          cnt = cnt + 1'b1;
        end
      end
    end

    assign minSlot    = peerSlot(tgtC[d], ownC[d]);
    assign altSlot    = peerSlot(altLoc, ownC[d]);
    assign minOcc     = occAll[d][minSlot*OCC_W +: OCC_W];
    assign altOcc     = occAll[d][altSlot*OCC_W +: OCC_W];
    assign minWins[d] = ({1'b0, minOcc} <= {altOcc, 1'b0});
    assign minIdx[d]  = minSlot;
    assign altIdx[d]  = altSlot;
  end

  logic [PEER_W-1:0] slotSel;
  logic [PORT_W-1:0] baseSel;

  assign slotSel = ctrl.detour  ? altIdx[ctrl.useDim2] : minIdx[ctrl.useDim2];
  assign baseSel = ctrl.useDim2 ? DIM2_BASE : DIM1_BASE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outPort   <= '0;
      outVc     <= 1'b0;
      outDetour <= 1'b0;
    end else if (ctrl.load) begin
      outPort   <= ctrl.eject ? PORT_W'(destTerm) : baseSel + PORT_W'(slotSel);
      outVc     <= ctrl.vcHigh;
      outDetour <= ctrl.detour;
    end
  end

endmodule

// File: rtl/fbfly_route.sv
module fbfly_route
  import fbfly_route_pkg::*;
#(
  parameter  int K       = 4,
  parameter  int CONC    = 4,
  parameter  int OCC_W   = 5,
  localparam int COORD_W = $clog2(K),
  localparam int TERM_W  = $clog2(CONC),
  localparam int ID_W    = 2 * COORD_W + TERM_W,
  localparam int PEERS   = K - 1,
  localparam int PORT_W  = $clog2(CONC + 2 * PEERS),
  localparam int ALT_W   = (K > 3) ? $clog2(K - 2) : 1
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  input  logic [ID_W-1:0]        destId,
  input  logic [COORD_W-1:0]     myRow,
  input  logic [COORD_W-1:0]     myCol,
  input  logic                   adaptiveEn,
  input  logic                   arrivedDetour,
  input  logic [ALT_W-1:0]       altPick,
  input  logic [PEERS*OCC_W-1:0] occDim1,
  input  logic [PEERS*OCC_W-1:0] occDim2,
  output logic                   respValid,
  output logic [PORT_W-1:0]      outPort,
  output logic                   outVc,
  output logic                   outDetour
);

  route_ctrl_t ctrl;
  logic        colMatch, rowMatch;
  logic [1:0]  minWins;

  fbfly_route_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .reqValid      (reqValid),
    .adaptiveEn    (adaptiveEn),
    .arrivedDetour (arrivedDetour),
    .colMatch      (colMatch),
    .rowMatch      (rowMatch),
    .minWins       (minWins),
    .ctrl          (ctrl),
    .respValid     (respValid)
  );

  fbfly_route_dp #(.K(K), .CONC(CONC), .OCC_W(OCC_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .destId    (destId),
    .myRow     (myRow),
    .myCol     (myCol),
    .altPick   (altPick),
    .occDim1   (occDim1),
    .occDim2   (occDim2),
    .ctrl      (ctrl),
    .colMatch  (colMatch),
    .rowMatch  (rowMatch),
    .minWins   (minWins),
    .outPort   (outPort),
    .outVc     (outVc),
    .outDetour (outDetour)
  );

endmodule

// File: rtl/fbfly_route_chk.sv
module fbfly_route_chk #(
  parameter  int K       = 4,
  parameter  int CONC    = 4,
  localparam int COORD_W = $clog2(K),
  localparam int TERM_W  = $clog2(CONC),
  localparam int ID_W    = 2 * COORD_W + TERM_W,
  localparam int PEERS   = K - 1,
  localparam int PORT_W  = $clog2(CONC + 2 * PEERS)
)(
  input logic               clk,
  input logic               rst_n,
  input logic               reqValid,
  input logic [ID_W-1:0]    destId,
  input logic [COORD_W-1:0] myRow,
  input logic [COORD_W-1:0] myCol,
  input logic               adaptiveEn,
  input logic               arrivedDetour,
  input logic               respValid,
  input logic [PORT_W-1:0]  outPort,
  input logic               outVc,
  input logic               outDetour
);

  logic atHome, colDiff;
  assign atHome  = (destId[ID_W-1 -: COORD_W] == myRow) && (destId[TERM_W +: COORD_W] == myCol);
  assign colDiff = (destId[TERM_W +: COORD_W] != myCol);

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respValid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !respValid);

  // R3
  eject_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && atHome |=> (outPort == PORT_W'($past(destId[TERM_W-1:0]))) && !outVc && !outDetour);

  // R4
  row_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && colDiff |=> (outPort >= PORT_W'(CONC)) && (outPort < PORT_W'(CONC + PEERS)));

  // R9
  second_hop_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && arrivedDetour && !atHome |=> outVc && !outDetour);

  // R10
  static_mode_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !adaptiveEn |=> !outDetour);

endmodule

bind fbfly_route fbfly_route_chk #(.K(K), .CONC(CONC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reqValid      (reqValid),
  .destId        (destId),
  .myRow         (myRow),
  .myCol         (myCol),
  .adaptiveEn    (adaptiveEn),
  .arrivedDetour (arrivedDetour),
  .respValid     (respValid),
  .outPort       (outPort),
  .outVc         (outVc),
  .outDetour     (outDetour)
);

// File: tb/fbfly_route_tb.sv
module fbfly_route_tb;

  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reqValid = 1'b0;
  logic [5:0]       destId = '0;
  logic [1:0]       myRow = '0, myCol = '0;
  logic             adaptiveEn = 1'b0, arrivedDetour = 1'b0;
  logic [0:0]       altPick = '0;
  logic [2:0][4:0]  o1 = '0, o2 = '0;
  logic             respValid;
  logic [3:0]       outPort;
  logic             outVc, outDetour;

  int checks = 0;
  int failures = 0;

  typedef struct {
    int    port;
    bit    vc;
    bit    det;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fbfly_route u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .destId(destId),
    .myRow(myRow), .myCol(myCol), .adaptiveEn(adaptiveEn),
    .arrivedDetour(arrivedDetour), .altPick(altPick),
    .occDim1(o1), .occDim2(o2),
    .respValid(respValid), .outPort(outPort), .outVc(outVc), .outDetour(outDetour)
  );

  // expected result derived from the requirement text
  function automatic exp_t model(input logic [5:0] dst, input int r, input int c,
                                 input bit ad, input bit dt, input int pk, input string tag);
    exp_t e;
    int dRow = int'(dst[5:4]);
    int dCol = int'(dst[3:2]);
    int own, tgt, base, minSlot, altCoord, altSlot, found, mo, ao;
    bit dim2, takeDet;
    e.tag = tag;
    if (dRow == r && dCol == c) begin
      e.port = int'(dst[1:0]); e.vc = 0; e.det = 0;
      return e;
    end
    dim2 = (dCol == c);
    own  = dim2 ? r : c;
    tgt  = dim2 ? dRow : dCol;
    base = dim2 ? 7 : 4;
    minSlot = (tgt > own) ? tgt - 1 : tgt;
    altCoord = 0; found = 0;
    for (int k = 0; k < 4; k++)
      if (k != own && k != tgt) begin
        if (found == pk) altCoord = k;
        found++;
      end
    altSlot = (altCoord > own) ? altCoord - 1 : altCoord;
    mo = dim2 ? int'(o2[minSlot]) : int'(o1[minSlot]);
    ao = dim2 ? int'(o2[altSlot]) : int'(o1[altSlot]);
    takeDet = ad && !dt && (mo > 2 * ao);
    e.port = base + (takeDet ? altSlot : minSlot);
    e.vc   = dt;
    e.det  = takeDet;
    return e;
  endfunction

  task automatic send(input logic [5:0] dst, input int r, input int c,
                      input bit ad, input bit dt, input int pk, input string tag);
    @(negedge clk);
    reqValid = 1'b1; destId = dst; myRow = 2'(r); myCol = 2'(c);
    adaptiveEn = ad; arrivedDetour = dt; altPick = 1'(pk);
    sb.push_back(model(dst, r, c, ad, dt, pk, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: every queued item must come out one edge after it was driven
  initial begin
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(posedge clk); #1;
      if (respValid) begin
        if (sb.size() == 0) check(0, "R2 spurious response", 1, 0);
        else begin
          e = sb.pop_front();
          check(outPort == 4'(e.port) && outVc == e.vc && outDetour == e.det, e.tag,
                {outPort, outVc, outDetour}, {4'(e.port), e.vc, e.det});
        end
      end else if (sb.size() != 0) begin
        e = sb.pop_front();
        check(0, {"R2 missing response ", e.tag}, 0, 1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    check(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(!respValid && outPort == 0 && !outVc && !outDetour, "R1 reset outputs",
          {respValid, outPort, outVc, outDetour}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 ejection at router (1,2), all four terminals, back to back
    for (int t = 0; t < 4; t++) send({2'd1, 2'd2, 2'(t)}, 1, 2, 0, 0, 0, "R3 eject");
    send({2'd1, 2'd2, 2'd3}, 1, 2, 1, 1, 0, "R3 R9 eject keeps vc0");
    idle();
    @(posedge clk); #2;
    check(!respValid, "R2 idle cycle", respValid, 0);

    // R4 R6 row ports, skip below and above own column
    send({2'd0, 2'd3, 2'd0}, 0, 0, 0, 0, 0, "R4 R6 col0->col3 port6");
    send({2'd3, 2'd1, 2'd1}, 2, 2, 0, 0, 0, "R4 R6 col2->col1 both differ port5");
    send({2'd2, 2'd3, 2'd2}, 1, 2, 0, 0, 0, "R4 R6 col2->col3 port6");
    // R5 R6 column ports
    send({2'd0, 2'd1, 2'd3}, 2, 1, 0, 0, 0, "R5 R6 row2->row0 port7");
    send({2'd3, 2'd0, 2'd0}, 1, 0, 0, 0, 0, "R5 R6 row1->row3 port9");
    idle();

    // R7 boundary: direct 6, alternative 3 keeps direct
    o1 = '0; o1[2] = 5'd6; o1[0] = 5'd3;
    send({2'd0, 2'd3, 2'd0}, 0, 0, 1, 0, 0, "R7 equal-to-twice keeps direct");
    idle();
    // R8 one above the boundary detours to col1 (slot 0)
    o1[2] = 5'd7;
    send({2'd0, 2'd3, 2'd0}, 0, 0, 1, 0, 0, "R8 detour altPick0 port4");
    idle();
    // R8 second candidate col2 (slot 1)
    o1[1] = 5'd3;
    send({2'd0, 2'd3, 2'd0}, 0, 0, 1, 0, 1, "R8 detour altPick1 port5");
    idle();
    // R8 column dimension detour to row3
    o2 = '0; o2[0] = 5'd9; o2[2] = 5'd4;
    send({2'd0, 2'd1, 2'd3}, 2, 1, 1, 0, 1, "R8 column detour port9");
    // R9 packet already detoured goes direct on vc1
    send({2'd0, 2'd1, 2'd3}, 2, 1, 1, 1, 1, "R9 second hop direct vc1");
    // R10 static mode ignores occupancy
    send({2'd0, 2'd1, 2'd3}, 2, 1, 0, 0, 1, "R10 static direct");
    // R4 adaptive row choice wins over column when both differ
    send({2'd3, 2'd3, 2'd1}, 1, 0, 1, 0, 0, "R4 R8 row dimension first");
    idle();
    repeat (3) @(posedge clk);
    #2;
    check(sb.size() == 0, "R2 all responses drained", sb.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule